// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block is the transmit DMA front end of a 10/100 Ethernet MAC. Software builds a ring of 16-byte descriptors in memory and hands each one to hardware by setting its ownership flag. It programs the ring's start address and then writes a poll-demand register. The fetcher then walks the ring. For every descriptor that hardware owns, it reads the frame buffer as 32-bit words and sends exactly the frame's bytes, in order, out of a byte-wide valid/ready stream. It then writes the first descriptor word back with ownership returned to software and steps to the next descriptor.

The walk goes on until the fetcher meets a descriptor that software owns. At that point it stops and flags that no transmit buffer was available. Each finished frame raises a transmit-done flag. Both flags are cleared by writing ones to them, and an interrupt line is asserted while any flag that the mask register enables is set. Frame buffers may start on any halfword boundary. A buffer that is not word aligned is still read as whole words, and the unwanted leading and trailing bytes are dropped.

Top module: `tx_ring_fetcher`

## Requirements
- R1: After a synchronous reset: mem_req, tx_valid, ring_busy and irq are 0, tx_status is 0, and the ring base and mask registers are 0.
- R2: A register write to offset 0x18 (any data) starts a ring walk while idle. Without such a write the block issues no memory request.
- R3: Descriptor layout, with byte offsets from the descriptor address: word 0 bit 31 = hardware owns it; word 1 bits 10:0 = frame length in bytes, bit 31 = end of ring; word 2 = byte address of the buffer. Word 3 is never accessed. Descriptors are 16 bytes apart.
- R4: When the walk reads a word 0 whose bit 31 is 0, it stops without sending any byte, returns to idle and sets tx_status bit 0 (no buffer; status register bit 3).
- R5: Each owned descriptor sends exactly length bytes, taken from ascending byte addresses starting at the buffer address. Byte n of a word is bits 8n+7:8n. tx_last is 1 only on the final byte. Buffer addresses ending in 0 or 2 both work.
- R6: After a frame is sent, word 0 of its descriptor is written as 0x00000000: owner cleared and collision field (bits 1:0) zero. Words 1 to 3 are not written. tx_status bit 1 (done; status register bit 4) is set.
- R7: After a descriptor whose end-of-ring bit is set, the next descriptor is read from the ring base. Otherwise it is read from the current address plus 16.
- R8: A write to offset 0x20 while idle sets the ring base and the next descriptor address. Such a write while busy is ignored.
- R9: Writing ones at offset 0x00 clears the matching status flags (bit 3 no buffer, bit 4 done). Zero bits leave flags unchanged.
- R10: irq is 1 exactly when a set status flag has its enable set in the mask register at offset 0x04 (same bit positions as the status).
- R11: Every memory request uses a word-aligned address. Once raised, a request keeps its address and direction until mem_ack.
- R12: Once tx_valid is raised, tx_valid, tx_data and tx_last hold until tx_ready.
- R13: A descriptor of length 0 sends no byte but is still written back and sets the done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Byte available |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts byte |
| tx_status | output | 2 | Bit 0 no buffer, bit 1 done |
| irq | output | 1 | Masked status interrupt |
| ring_busy | output | 1 | Ring walk in progress |

## Verification
A wrong descriptor pointer shows up within one frame. The bytes then come from the wrong buffer, or the walk stops early with the no-buffer flag, and the stream comparison catches it at the first byte. A bad remaining-byte count or lane offset corrupts that frame's first or last word: a byte is missing, an extra byte appears, or tx_last lands on the wrong byte. Wrap and base-register errors only surface on the frame after the end-of-ring descriptor. For that reason a single descriptor is re-armed after each pass and must be the one that transmits.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OWN, ST_CTRL, ST_BUF, ST_DATA, ST_WBACK
  } fetch_state_t;

  localparam int DESC_STRIDE = 16;
  localparam int OWN_BIT     = 31;
  localparam int EOR_BIT     = 31;
  localparam int NOBUF_BIT   = 3;
  localparam int DONE_BIT    = 4;
endpackage

// File: rtl/tx_ring_regs.sv
module tx_ring_regs #(
  parameter int AW  = 32,
  parameter int RAW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [RAW-1:0] wr_addr,
  input  logic [31:0]    wr_data,
  input  logic           busy,
  input  logic           set_nobuf,
  input  logic           set_done,
  output logic           kick,
  output logic           base_ld,
  output logic [AW-1:0]  base_q,
  output logic [1:0]     stat_q,
  output logic           irq
);
  import tx_ring_pkg::*;

  localparam logic [RAW-1:0] OFS_STAT = RAW'(8'h00);
  localparam logic [RAW-1:0] OFS_MASK = RAW'(8'h04);
  localparam logic [RAW-1:0] OFS_POLL = RAW'(8'h18);
  localparam logic [RAW-1:0] OFS_BASE = RAW'(8'h20);

  logic [1:0] mask_q, stat_n, mask_n, clr;
  logic       unused_wdata;

  assign unused_wdata = ^wr_data;
  assign kick    = wr_en && (wr_addr == OFS_POLL);
  assign base_ld = wr_en && (wr_addr == OFS_BASE) && !busy;

  always_comb begin
    clr    = (wr_en && wr_addr == OFS_STAT) ? {wr_data[DONE_BIT], wr_data[NOBUF_BIT]} : 2'b00;
    stat_n = (stat_q & ~clr) | {set_done, set_nobuf};
    mask_n = (wr_en && wr_addr == OFS_MASK) ? {wr_data[DONE_BIT], wr_data[NOBUF_BIT]} : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      mask_q <= '0;
      stat_q <= '0;
      irq    <= 1'b0;
    end else begin
      if (base_ld) base_q <= wr_data[AW-1:0];
      mask_q <= mask_n;
      stat_q <= stat_n;
      irq    <= |(stat_n & mask_n);
    end
  end
endmodule

// File: rtl/tx_byte_unpack.sv
module tx_byte_unpack (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [31:0] load_word,
  input  logic [1:0]  load_idx,
  input  logic [2:0]  load_cnt,
  input  logic        load_last,
  output logic        idle,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready
);
  logic [31:0] word_q;
  logic [1:0]  idx_q;
  logic [2:0]  cnt_q;
  logic        last_q;

  assign idle     = (cnt_q == 3'd0);
  assign tx_valid = !idle;
  assign tx_data  = word_q[{idx_q, 3'b000} +: 8];
  assign tx_last  = last_q && (cnt_q == 3'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else if (load) begin
      word_q <= load_word;
      idx_q  <= load_idx;
      cnt_q  <= load_cnt;
      last_q <= load_last;
    end else if (tx_valid && tx_ready) begin
      idx_q <= idx_q + 2'd1;
      cnt_q <= cnt_q - 3'd1;
    end
  end
endmodule

// File: rtl/tx_ring_ctrl.sv
module tx_ring_ctrl #(
  parameter int AW    = 32,
  parameter int LEN_W = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          kick,
  input  logic          base_ld,
  input  logic [AW-1:0] base_new,
  input  logic [AW-1:0] base_q,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          up_load,
  output logic [1:0]    up_idx,
  output logic [2:0]    up_cnt,
  output logic          up_last,
  input  logic          up_idle,
  output logic          busy,
  output logic          set_nobuf,
  output logic          set_done
);
  import tx_ring_pkg::*;

  localparam logic [1:0] COLL_NONE = 2'b00;

  fetch_state_t st_q;
  logic [AW-1:0]    cur_q, rptr_q;
  logic [LEN_W-1:0] remain_q;
  logic [1:0]       boff_q;
  logic             eor_q;
  logic             data_rd;
  logic [2:0]       avail, take;
  logic             unused_rd;

  assign unused_rd = ^mem_rdata[30:LEN_W];
  assign busy      = (st_q != ST_IDLE);
  assign data_rd   = (st_q == ST_DATA) && (remain_q != '0) && up_idle;
  assign mem_req   = (st_q == ST_OWN) || (st_q == ST_CTRL) || (st_q == ST_BUF)
                   || (st_q == ST_WBACK) || data_rd;
  assign mem_we    = (st_q == ST_WBACK);
  assign mem_wdata = {1'b0, 29'd0, COLL_NONE};

  always_comb begin
    case (st_q)
      ST_OWN:   mem_addr = cur_q;
      ST_CTRL:  mem_addr = cur_q + AW'(4);
      ST_BUF:   mem_addr = cur_q + AW'(8);
      ST_WBACK: mem_addr = cur_q;
      default:  mem_addr = rptr_q;
    endcase
  end

  assign avail     = 3'd4 - {1'b0, boff_q};
  assign take      = (remain_q < LEN_W'(avail)) ? remain_q[2:0] : avail;
  assign up_load   = data_rd && mem_ack;
  assign up_idx    = boff_q;
  assign up_cnt    = take;
  assign up_last   = (remain_q == LEN_W'(take));
  assign set_nobuf = (st_q == ST_OWN) && mem_ack && !mem_rdata[OWN_BIT];
  assign set_done  = (st_q == ST_WBACK) && mem_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      cur_q    <= '0;
      rptr_q   <= '0;
      remain_q <= '0;
      boff_q   <= '0;
      eor_q    <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (base_ld) cur_q <= base_new;
          if (kick) st_q <= ST_OWN;
        end
        ST_OWN: if (mem_ack) st_q <= mem_rdata[OWN_BIT] ? ST_CTRL : ST_IDLE;
        ST_CTRL: if (mem_ack) begin
          remain_q <= mem_rdata[LEN_W-1:0];
          eor_q    <= mem_rdata[EOR_BIT];
          st_q     <= ST_BUF;
        end
        ST_BUF: if (mem_ack) begin
          rptr_q <= {mem_rdata[AW-1:2], 2'b00};
          boff_q <= mem_rdata[1:0];
          st_q   <= (remain_q == '0) ? ST_WBACK : ST_DATA;
        end
        ST_DATA: begin
          if (up_load) begin
            remain_q <= remain_q - LEN_W'(take);
            rptr_q   <= rptr_q + AW'(4);
            boff_q   <= 2'b00;
          end else if (remain_q == '0 && up_idle) begin
            st_q <= ST_WBACK;
          end
        end
        ST_WBACK: if (mem_ack) begin
          cur_q <= eor_q ? base_q : cur_q + AW'(DESC_STRIDE);
          st_q  <= ST_OWN;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_ring_fetcher.sv
module tx_ring_fetcher #(
  parameter int AW    = 32,
  parameter int RAW   = 8,
  parameter int LEN_W = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [31:0]    mem_wdata,
  input  logic           mem_ack,
  input  logic [31:0]    mem_rdata,
  output logic           tx_valid,
  output logic [7:0]     tx_data,
  output logic           tx_last,
  input  logic           tx_ready,
  output logic [1:0]     tx_status,
  output logic           irq,
  output logic           ring_busy
);
  logic          kick, base_ld, set_nobuf, set_done;
  logic [AW-1:0] base_q;
  logic          up_load, up_last, up_idle;
  logic [1:0]    up_idx;
  logic [2:0]    up_cnt;

  tx_ring_regs #(.AW(AW), .RAW(RAW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .busy(ring_busy), .set_nobuf(set_nobuf),
    .set_done(set_done), .kick(kick), .base_ld(base_ld),
    .base_q(base_q), .stat_q(tx_status), .irq(irq)
  );

  tx_ring_ctrl #(.AW(AW), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst(rst), .kick(kick), .base_ld(base_ld),
    .base_new(reg_wdata[AW-1:0]), .base_q(base_q),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .up_load(up_load), .up_idx(up_idx), .up_cnt(up_cnt),
    .up_last(up_last), .up_idle(up_idle), .busy(ring_busy),
    .set_nobuf(set_nobuf), .set_done(set_done)
  );

  tx_byte_unpack u_unpack (
    .clk(clk), .rst(rst), .load(up_load), .load_word(mem_rdata),
    .load_idx(up_idx), .load_cnt(up_cnt), .load_last(up_last),
    .idle(up_idle), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .tx_ready(tx_ready)
  );
endmodule

// File: rtl/tx_ring_fetcher_chk.sv
module tx_ring_fetcher_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_ack,
  input logic          tx_valid,
  input logic [7:0]    tx_data,
  input logic          tx_last,
  input logic          tx_ready,
  input logic          ring_busy
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> mem_addr[1:0] == 2'b00); // R11
  AST_STREAM_HOLD: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ring_busy |-> !mem_req && !tx_valid); // R2
  AST_WB_RELEASE: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_we |-> mem_wdata == 32'h0); // R6
endmodule

bind tx_ring_fetcher tx_ring_fetcher_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
  .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
  .tx_ready(tx_ready), .ring_busy(ring_busy)
);

// File: tb/tx_ring_fetcher_tb.sv
module tx_ring_fetcher_tb;
  localparam logic [31:0] RING = 32'h40;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        tx_valid, tx_last, tx_ready = 1'b0;
  logic [7:0]  tx_data;
  logic [1:0]  tx_status;
  logic        irq, ring_busy;

  logic [31:0] mem [0:255];
  logic [7:0]  rx_b[$], ex_b[$];
  logic        rx_l[$], ex_l[$];
  int checks = 0, errors = 0, cyc = 0;
  int rx_cnt_snap;
  logic [31:0] w1_save [0:3];

  always #5 clk = ~clk;

  tx_ring_fetcher u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_last(tx_last), .tx_ready(tx_ready), .tx_status(tx_status),
    .irq(irq), .ring_busy(ring_busy)
  );

  always @(negedge clk) begin
    logic rdy;
    if (!rst && mem_req && ($urandom_range(3, 0) != 0)) begin
      mem_ack   = 1'b1;
      mem_rdata = mem[mem_addr[9:2]];
      if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
    end else begin
      mem_ack = 1'b0;
    end
    rdy = ($urandom_range(4, 0) != 0);
    tx_ready = rdy;
    if (!rst && tx_valid && rdy) begin
      rx_b.push_back(tx_data);
      rx_l.push_back(tx_last);
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected under 150000", cyc);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (ring_busy && n < 5000) begin @(negedge clk); n++; end
    chk(n < 5000, tag, n, 0);
  endtask

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return mem[a[9:2]][{a[1:0], 3'b000} +: 8];
  endfunction

  task automatic arm(input int i, input int len, input int off, input bit eor);
    logic [31:0] d = RING + 32'(16 * i);
    logic [31:0] b = 32'h100 + 32'(64 * i) + 32'(off);
    for (int k = 0; k < 16; k++) mem[(32'h100 + 32'(64 * i)) / 4 + k] = $urandom;
    mem[d / 4]     = 32'h8000_0003;
    mem[d / 4 + 1] = {eor, 2'b00, 2'b11, 16'h0, 11'(len)};
    mem[d / 4 + 2] = b;
    mem[d / 4 + 3] = 32'hC0DE_0000 + 32'(i);
    w1_save[i] = mem[d / 4 + 1];
    for (int k = 0; k < len; k++) begin
      ex_b.push_back(mbyte(b + 32'(k)));
      ex_l.push_back(k == len - 1);
    end
  endtask

  task automatic cmp_stream(input string tag);
    chk(rx_b.size() == ex_b.size(), {tag, " byte count"}, rx_b.size(), ex_b.size());
    for (int k = 0; k < ex_b.size() && k < rx_b.size(); k++) begin
      chk(rx_b[k] == ex_b[k], {tag, " byte"}, rx_b[k], ex_b[k]);
      chk(rx_l[k] == ex_l[k], {tag, " last flag"}, rx_l[k], ex_l[k]);
    end
    rx_b.delete(); rx_l.delete(); ex_b.delete(); ex_l.delete();
  endtask

  task automatic check_wb(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      chk(mem[(RING + 32'(16 * i)) / 4] == 32'h0, {tag, " word0 released"},
          mem[(RING + 32'(16 * i)) / 4], 0);
      chk(mem[(RING + 32'(16 * i)) / 4 + 1] == w1_save[i], {tag, " word1 untouched"},
          mem[(RING + 32'(16 * i)) / 4 + 1], w1_save[i]);
      chk(mem[(RING + 32'(16 * i)) / 4 + 3] == 32'hC0DE_0000 + 32'(i), {tag, " word3 untouched"},
          mem[(RING + 32'(16 * i)) / 4 + 3], 32'hC0DE_0000 + 32'(i));
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < 256; k++) mem[k] = 32'h0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!mem_req && !tx_valid && !ring_busy, "R1 idle outputs", {mem_req, tx_valid, ring_busy}, 0);
    chk(tx_status == 2'b00 && !irq, "R1 status and irq", {tx_status, irq}, 0);

    reg_write(8'h20, RING);
    repeat (10) @(negedge clk);
    chk(!mem_req && !ring_busy, "R2 no request without poll", mem_req, 0);

    // R4: empty ring, no mask
    reg_write(8'h18, 32'h0);
    chk(ring_busy, "R2 poll starts walk", ring_busy, 1);
    wait_idle("R4 walk ends");
    chk(tx_status == 2'b01, "R4 no-buffer flag", tx_status, 2'b01);
    chk(rx_b.size() == 0, "R4 no bytes sent", rx_b.size(), 0);
    chk(!irq, "R10 masked flag gives no irq", irq, 0);
    reg_write(8'h04, 32'h08);
    @(negedge clk);
    chk(irq, "R10 enabled flag gives irq", irq, 1);
    reg_write(8'h00, 32'h10);
    chk(tx_status == 2'b01, "R9 zero bit leaves flag", tx_status, 2'b01);
    reg_write(8'h00, 32'h08);
    chk(tx_status == 2'b00, "R9 one bit clears flag", tx_status, 2'b00);
    @(negedge clk);
    chk(!irq, "R10 irq drops after clear", irq, 0);

    // Pass 1: directed corners
    arm(0, 1, 2, 1'b0);
    arm(1, $urandom_range(40, 5), 0, 1'b0);
    arm(2, 0, 2, 1'b0);
    arm(3, $urandom_range(40, 5), 2, 1'b1);
    reg_write(8'h04, 32'h10);
    reg_write(8'h18, 32'h0);
    wait_idle("R5 pass1 ends");
    cmp_stream("R5 R13 pass1 stream");
    check_wb(4, "R6 R13 pass1");
    chk(tx_status == 2'b11, "R6 R4 done and stop flags", tx_status, 2'b11);
    chk(irq, "R10 done flag irq", irq, 1);
    reg_write(8'h00, 32'h18);
    chk(tx_status == 2'b00, "R9 clear both", tx_status, 0);

    // Pass 2: random, base write while busy is ignored
    for (int i = 0; i < 4; i++) arm(i, $urandom_range(40, 1), 2 * $urandom_range(1, 0), i == 3);
    reg_write(8'h18, 32'h0);
    reg_write(8'h20, 32'h300);
    wait_idle("R3 pass2 ends");
    cmp_stream("R3 R5 pass2 stream");
    check_wb(4, "R6 pass2");

    // R7 R8: wrap returned to the original base
    arm(0, 5, 2, 1'b0);
    rx_cnt_snap = 0;
    reg_write(8'h18, 32'h0);
    wait_idle("R7 rearm ends");
    cmp_stream("R7 R8 wrap to base");
    chk(tx_status[0], "R4 stop at released descriptor", tx_status, 2'b01);

    // Random passes
    for (int p = 0; p < 3; p++) begin
      reg_write(8'h00, 32'h18);
      reg_write(8'h20, RING);
      for (int i = 0; i < 4; i++) arm(i, $urandom_range(40, 0), 2 * $urandom_range(1, 0), i == 3);
      reg_write(8'h18, 32'h0);
      wait_idle("R5 random pass ends");
      cmp_stream("R5 random stream");
      check_wb(4, "R6 random");
    end
    finish_run();
  end
endmodule